// File: doc/BRIEF.md
# Shared-Bank Split-Read Memory Front-End

This block places several independent clients in front of one slow, shared memory bank. Each client is given a fixed window of the bank. Its local word addresses are offset by the base of that window before they reach the memory. A client stores a word through a write port with a valid/ready handshake. Reading takes two separate steps. First the client posts a read request that carries only an address. Later it collects the word from a retrieve port that has its own valid/ready handshake. Between the two steps the client is free to post further requests or writes.

A round-robin arbiter picks at most one client per cycle and forwards its command on a single command port toward the memory. The memory may take a different number of cycles for each read, but it must complete reads in the order it accepted them. A small tag queue records which client issued each read. Every returning word is steered into the response queue of that client. A read is admitted only when space for its answer is already reserved in that client's queue, so the memory response path has no backpressure. A local address outside the client's window is refused at once, raises an error pulse and never reaches the memory.

Top module: `mem_share_front`

## Requirements
- R1: A write with local address below REGION_WORDS, granted while mem_cmd_ready is high, drives in that cycle mem_cmd_valid=1, mem_cmd_we=1, mem_cmd_addr = i*REGION_WORDS + local address (i = client index), mem_cmd_wdata = the client's data, and wr_ready[i]=1.
- R2: A write whose valid is removed before wr_ready was seen high is not stored. While mem_cmd_ready is low, wr_ready stays low and no command is taken, and the memory word at that address keeps its previous value.
- R3: A read request with an in-range address that is granted drives a command with mem_cmd_we=0 and mem_cmd_addr = i*REGION_WORDS + local address, and raises rq_ready[i] in that cycle.
- R4: Read data returned by the memory (in issue order, with any latency of at least one cycle) reaches each client's retrieve port in the order that client's requests were accepted, and holds the memory contents at the time of the command.
- R5: rt_valid[i] is high whenever client i has returned data not yet taken. rt_data[i] shows the oldest such word. Both hold unchanged until a cycle with rt_valid[i] and rt_ready[i] both high, which removes that word.
- R6: Arbitration is round-robin. After reset client 0 has the highest priority. After a grant to client k the search starts at k+1, wrapping to 0, and at most one command is issued per cycle.
- R7: When one client presents a write and a read request in the same cycle, the write is issued first and the read follows in a later cycle.
- R8: A local address of REGION_WORDS or more on the write or request port is acknowledged in the same cycle (ready high) with addr_err[i]=1. It issues no memory command, and a refused read produces no retrieve data.
- R9: A client holds at most RSP_DEPTH reads that are issued or not yet retrieved. With that many held, rq_ready[i] stays low for an in-range request until a retrieve pop frees a slot. A request is also held while the shared tag queue holds TAG_DEPTH reads.
- R10: After reset, with all inputs idle, mem_cmd_valid, every rt_valid, every wr_ready and every addr_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | NUM_CLIENTS | Per-client write valid |
| wr_addr | input | NUM_CLIENTS*LOCAL_AW | Per-client local write address, client i in slice i |
| wr_data | input | NUM_CLIENTS*DATA_W | Per-client write data |
| wr_ready | output | NUM_CLIENTS | Write accepted this cycle |
| rq_valid | input | NUM_CLIENTS | Per-client read request valid |
| rq_addr | input | NUM_CLIENTS*LOCAL_AW | Per-client local read address |
| rq_ready | output | NUM_CLIENTS | Read request accepted this cycle |
| rt_valid | output | NUM_CLIENTS | Retrieve data available |
| rt_data | output | NUM_CLIENTS*DATA_W | Oldest returned word per client |
| rt_ready | input | NUM_CLIENTS | Client takes the shown word |
| addr_err | output | NUM_CLIENTS | Out-of-window address refused this cycle |
| mem_cmd_valid | output | 1 | Command to memory present |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_we | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | MEM_AW | Bank word address |
| mem_cmd_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read word returned by memory, in issue order |
| mem_rsp_data | input | DATA_W | Returned word |

## Verification
The bench builds the block with three clients, 16-word windows in a 64-word bank and 5-bit local addresses. With these values the local addresses 16 to 31 exist on the ports, so the out-of-window refusal can be exercised. A response depth of 4 lets five reads from one client hit the reservation limit within a few cycles. A tag depth of 8 lies below the twelve reads the three clients could hold together, so the shared tag limit can stall reads during the concurrent random phase. An odd client count makes the arbiter pointer wrap from 2 to 0 rather than at a power of two.

// File: rtl/msf_pkg.sv
package msf_pkg;
   typedef enum logic {
      KIND_READ  = 1'b0,
      KIND_WRITE = 1'b1
   } cmd_kind_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/msf_fifo.sv
module msf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = msf_pkg::idx_w(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("msf_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          push_ok, pop_ok;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign dout    = store[rp];

   always_ff @(posedge clk) begin
      if (push_ok) store[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= bump(wp);
         if (pop_ok)  rp <= bump(rp);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_fifo_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   assert_fifo_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/msf_rr_arb.sv
module msf_rr_arb #(
   parameter int N = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N-1:0]                 req,
   input  logic                         advance,
   output logic [N-1:0]                 grant,
   output logic [msf_pkg::idx_w(N)-1:0] gidx
);
   localparam int IW = msf_pkg::idx_w(N);

   generate
      if (N == 1) begin : g_single
         assign grant = req;
         assign gidx  = '0;
      end else begin : g_rr
         logic [IW-1:0] ptr;
         logic          found;

         always_comb begin
            grant = '0;
            gidx  = '0;
            found = 1'b0;
            for (int k = 0; k < N; k++) begin
               int s;
               s = int'(ptr) + k;
               if (s >= N) s = s - N;
               if (!found && req[s]) begin
                  found    = 1'b1;
                  grant[s] = 1'b1;
                  gidx     = IW'(s);
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ptr <= '0;
            else if (advance) ptr <= (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
         end
      end
   endgenerate

   assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_grant_to_requester_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
   assert_advance_has_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> (grant != '0));
endmodule

// File: rtl/msf_client.sv
module msf_client #(
   parameter int IDX       = 0,
   parameter int LAW       = 5,
   parameter int MAW       = 6,
   parameter int DW        = 16,
   parameter int REGION    = 16,
   parameter int RSP_DEPTH = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic [LAW-1:0]       wr_addr,
   input  logic                 rq_valid,
   input  logic [LAW-1:0]       rq_addr,
   input  logic                 tag_room,
   input  logic                 granted,
   output logic                 req,
   output msf_pkg::cmd_kind_e   kind,
   output logic [MAW-1:0]       phys_addr,
   output logic                 wr_ready,
   output logic                 rq_ready,
   output logic                 addr_err,
   input  logic                 rsp_push,
   input  logic [DW-1:0]        rsp_data,
   input  logic                 rt_ready,
   output logic                 rt_valid,
   output logic [DW-1:0]        rt_data
);
   import msf_pkg::*;

   localparam int            CW   = $clog2(RSP_DEPTH + 1);
   localparam logic [LAW:0]  LIM  = (LAW + 1)'(REGION);
   localparam logic [MAW-1:0] BASE = MAW'(IDX * REGION);

   logic          wr_bad, rd_bad, ok_wr, ok_rd, room;
   logic          rd_fire, rt_pop, rsp_empty, rsp_full;
   logic [CW-1:0] reserved;

   assign wr_bad   = wr_valid && ({1'b0, wr_addr} >= LIM);
   assign rd_bad   = rq_valid && ({1'b0, rq_addr} >= LIM);
   assign room     = (reserved < CW'(RSP_DEPTH)) && !rsp_full && tag_room;
   assign ok_wr    = wr_valid && !wr_bad;
   assign ok_rd    = rq_valid && !rd_bad && room;

   assign req       = ok_wr || ok_rd;
   assign kind      = ok_wr ? KIND_WRITE : KIND_READ;
   assign phys_addr = BASE + MAW'(ok_wr ? wr_addr : rq_addr);

   assign rd_fire  = granted && (kind == KIND_READ);
   assign wr_ready = wr_bad || (granted && (kind == KIND_WRITE));
   assign rq_ready = rd_bad || rd_fire;
   assign addr_err = wr_bad || rd_bad;

   assign rt_valid = !rsp_empty;
   assign rt_pop   = rt_valid && rt_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reserved <= '0;
      end else begin
         case ({rd_fire, rt_pop})
            2'b10:   reserved <= reserved + 1'b1;
            2'b01:   reserved <= reserved - 1'b1;
            default: reserved <= reserved;
         endcase
      end
   end

   msf_fifo #(.W(DW), .DEPTH(RSP_DEPTH)) u_rsp (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rsp_push),
      .din   (rsp_data),
      .pop   (rt_pop),
      .dout  (rt_data),
      .empty (rsp_empty),
      .full  (rsp_full)
   );

   assert_hold_until_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_valid && !rt_ready) |=> (rt_valid && $stable(rt_data)));
   assert_credit_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reserved <= CW'(RSP_DEPTH));
   assert_bad_write_not_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bad && !ok_rd) |-> !granted);
endmodule

// File: rtl/mem_share_front.sv
module mem_share_front #(
   parameter int NUM_CLIENTS  = 3,
   parameter int REGION_WORDS = 16,
   parameter int MEM_AW       = 6,
   parameter int LOCAL_AW     = 5,
   parameter int DATA_W       = 16,
   parameter int RSP_DEPTH    = 4,
   parameter int TAG_DEPTH    = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_CLIENTS-1:0]          wr_valid,
   input  logic [NUM_CLIENTS*LOCAL_AW-1:0] wr_addr,
   input  logic [NUM_CLIENTS*DATA_W-1:0]   wr_data,
   output logic [NUM_CLIENTS-1:0]          wr_ready,
   input  logic [NUM_CLIENTS-1:0]          rq_valid,
   input  logic [NUM_CLIENTS*LOCAL_AW-1:0] rq_addr,
   output logic [NUM_CLIENTS-1:0]          rq_ready,
   output logic [NUM_CLIENTS-1:0]          rt_valid,
   output logic [NUM_CLIENTS*DATA_W-1:0]   rt_data,
   input  logic [NUM_CLIENTS-1:0]          rt_ready,
   output logic [NUM_CLIENTS-1:0]          addr_err,
   output logic                            mem_cmd_valid,
   input  logic                            mem_cmd_ready,
   output logic                            mem_cmd_we,
   output logic [MEM_AW-1:0]               mem_cmd_addr,
   output logic [DATA_W-1:0]               mem_cmd_wdata,
   input  logic                            mem_rsp_valid,
   input  logic [DATA_W-1:0]               mem_rsp_data
);
   import msf_pkg::*;

   localparam int IW = idx_w(NUM_CLIENTS);

   generate
      if (NUM_CLIENTS < 1) begin : g_bad_n
         $error("mem_share_front: NUM_CLIENTS must be at least 1");
      end
      if (NUM_CLIENTS * REGION_WORDS > (1 << MEM_AW)) begin : g_bad_fit
         $error("mem_share_front: client windows exceed the bank");
      end
      if ((1 << LOCAL_AW) < REGION_WORDS) begin : g_bad_law
         $error("mem_share_front: LOCAL_AW too narrow for REGION_WORDS");
      end
   endgenerate

   logic [NUM_CLIENTS-1:0] c_req, grant, granted, rsp_push;
   cmd_kind_e              c_kind [NUM_CLIENTS];
   logic [MEM_AW-1:0]      c_phys [NUM_CLIENTS];
   logic [IW-1:0]          gidx, tag_head;
   logic                   fire, tag_empty, tag_full;

   assign mem_cmd_valid = |c_req;
   assign fire          = mem_cmd_valid && mem_cmd_ready;

   generate
      for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_cli
         assign granted[i]  = fire && grant[i];
         assign rsp_push[i] = mem_rsp_valid && !tag_empty && (tag_head == IW'(i));

         msf_client #(
            .IDX(i), .LAW(LOCAL_AW), .MAW(MEM_AW), .DW(DATA_W),
            .REGION(REGION_WORDS), .RSP_DEPTH(RSP_DEPTH)
         ) u_cli (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_valid  (wr_valid[i]),
            .wr_addr   (wr_addr[i*LOCAL_AW +: LOCAL_AW]),
            .rq_valid  (rq_valid[i]),
            .rq_addr   (rq_addr[i*LOCAL_AW +: LOCAL_AW]),
            .tag_room  (!tag_full),
            .granted   (granted[i]),
            .req       (c_req[i]),
            .kind      (c_kind[i]),
            .phys_addr (c_phys[i]),
            .wr_ready  (wr_ready[i]),
            .rq_ready  (rq_ready[i]),
            .addr_err  (addr_err[i]),
            .rsp_push  (rsp_push[i]),
            .rsp_data  (mem_rsp_data),
            .rt_ready  (rt_ready[i]),
            .rt_valid  (rt_valid[i]),
            .rt_data   (rt_data[i*DATA_W +: DATA_W])
         );
      end
   endgenerate

   msf_rr_arb #(.N(NUM_CLIENTS)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (c_req),
      .advance (fire),
      .grant   (grant),
      .gidx    (gidx)
   );

   always_comb begin
      mem_cmd_we    = 1'b0;
      mem_cmd_addr  = '0;
      mem_cmd_wdata = '0;
      for (int i = 0; i < NUM_CLIENTS; i++) begin
         if (grant[i]) begin
            mem_cmd_we    = (c_kind[i] == KIND_WRITE);
            mem_cmd_addr  = c_phys[i];
            mem_cmd_wdata = wr_data[i*DATA_W +: DATA_W];
         end
      end
   end

   msf_fifo #(.W(IW), .DEPTH(TAG_DEPTH)) u_tag (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fire && !mem_cmd_we),
      .din   (gidx),
      .pop   (mem_rsp_valid),
      .dout  (tag_head),
      .empty (tag_empty),
      .full  (tag_full)
   );

   assert_cmd_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> ((int'(mem_cmd_addr) >= int'(gidx) * REGION_WORDS) &&
                (int'(mem_cmd_addr) <  (int'(gidx) + 1) * REGION_WORDS)));
   assert_rsp_has_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> !tag_empty);
   assert_one_push_per_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rsp_push) == (mem_rsp_valid ? 1 : 0));
endmodule

// File: tb/sim_mem_share_front.sv
`timescale 1ns/1ps
module sim_mem_share_front;
   localparam int NC = 3, LAW = 5, MAW = 6, DW = 16, REG = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NC-1:0]     b_wv = '0, b_rv = '0, b_rr = '0;
   logic [LAW-1:0]    b_wa [NC], b_ra [NC];
   logic [DW-1:0]     b_wd [NC];
   logic [NC*LAW-1:0] p_wa, p_ra;
   logic [NC*DW-1:0]  p_wd, rt_data;
   logic [NC-1:0]     wr_ready, rq_ready, rt_valid, addr_err;
   logic              mem_cmd_valid, mem_cmd_we, m_ready, dir_ready = 1'b1;
   logic              rnd_mode = 1'b0, rnd_bit = 1'b1;
   logic [MAW-1:0]    mem_cmd_addr;
   logic [DW-1:0]     mem_cmd_wdata, m_rsp_d = '0;
   logic              m_rsp_v = 1'b0;

   assign m_ready = rnd_mode ? rnd_bit : dir_ready;

   generate
      for (genvar c = 0; c < NC; c++) begin : g_pk
         assign p_wa[c*LAW +: LAW] = b_wa[c];
         assign p_ra[c*LAW +: LAW] = b_ra[c];
         assign p_wd[c*DW +: DW]   = b_wd[c];
      end
   endgenerate

   mem_share_front #(.NUM_CLIENTS(NC), .REGION_WORDS(REG), .MEM_AW(MAW),
      .LOCAL_AW(LAW), .DATA_W(DW), .RSP_DEPTH(4), .TAG_DEPTH(8)) u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(b_wv), .wr_addr(p_wa), .wr_data(p_wd), .wr_ready(wr_ready),
      .rq_valid(b_rv), .rq_addr(p_ra), .rq_ready(rq_ready),
      .rt_valid(rt_valid), .rt_data(rt_data), .rt_ready(b_rr),
      .addr_err(addr_err),
      .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(m_ready), .mem_cmd_we(mem_cmd_we),
      .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
      .mem_rsp_valid(m_rsp_v), .mem_rsp_data(m_rsp_d));

   // memory model: in-order completion, random latency
   typedef struct packed { logic we; logic [MAW-1:0] a; logic [DW-1:0] d; } ent_t;
   typedef struct { int due; logic [DW-1:0] d; } rsp_t;
   ent_t        log_q [$];
   rsp_t        rsp_q [$];
   logic [DW-1:0] marr [1 << MAW];
   int          cyc = 0, last_due = 0;

   initial for (int i = 0; i < (1 << MAW); i++) marr[i] = '0;

   always @(posedge clk) begin
      int due;
      if (!rst_n) begin
         rsp_q.delete();
      end else begin
         if (m_rsp_v) void'(rsp_q.pop_front());
         if (mem_cmd_valid && m_ready) begin
            log_q.push_back('{mem_cmd_we, mem_cmd_addr, mem_cmd_wdata});
            if (mem_cmd_we) marr[mem_cmd_addr] = mem_cmd_wdata;
            else begin
               due = cyc + $urandom_range(1, 9);
               if (due <= last_due) due = last_due + 1;
               last_due = due;
               rsp_q.push_back('{due, marr[mem_cmd_addr]});
            end
         end
      end
      cyc++;
   end

   always @(negedge clk) begin
      m_rsp_v = rst_n && (rsp_q.size() > 0) && (rsp_q[0].due <= cyc);
      m_rsp_d = m_rsp_v ? rsp_q[0].d : '0;
      if (rnd_mode) rnd_bit = ($urandom_range(0, 3) != 0);
   end

   int nchk = 0, nerr = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input int c, input int a, input logic [DW-1:0] d);
      bit acc = 0;
      @(negedge clk);
      b_wv[c] = 1'b1; b_wa[c] = LAW'(a); b_wd[c] = d;
      for (int n = 0; n < 500 && !acc; n++) begin
         #2 acc = wr_ready[c];
         @(negedge clk);
      end
      b_wv[c] = 1'b0;
      chk(acc, "R1 write handshake", acc, 1);
   endtask

   task automatic do_read(input int c, input int a);
      bit acc = 0;
      @(negedge clk);
      b_rv[c] = 1'b1; b_ra[c] = LAW'(a);
      for (int n = 0; n < 500 && !acc; n++) begin
         #2 acc = rq_ready[c];
         @(negedge clk);
      end
      b_rv[c] = 1'b0;
      chk(acc, "R3 read request handshake", acc, 1);
   endtask

   task automatic do_pop(input int c, output logic [DW-1:0] d);
      bit acc = 0;
      d = '0;
      @(negedge clk);
      b_rr[c] = 1'b1;
      for (int n = 0; n < 500 && !acc; n++) begin
         #2 acc = rt_valid[c];
         d = rt_data[c*DW +: DW];
         @(negedge clk);
      end
      b_rr[c] = 1'b0;
      chk(acc, "R5 retrieve handshake", acc, 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      log_q.delete();
      @(negedge clk);
      #2;
      chk(mem_cmd_valid == 0, "R10 mem_cmd_valid after reset", mem_cmd_valid, 0);
      chk(rt_valid == 0, "R10 rt_valid after reset", rt_valid, 0);
      chk(addr_err == 0 && wr_ready == 0, "R10 err/ready after reset", {addr_err, wr_ready}, 0);
   endtask

   typedef struct packed {
      logic [1:0] cli; logic rd; logic [LAW-1:0] la; logic [DW-1:0] d; logic [MAW-1:0] pa;
   } vec_t;
   localparam vec_t VEC [9] = '{
      '{2'd0, 1'b0, 5'd3,  16'h1111, 6'd3},
      '{2'd1, 1'b0, 5'd0,  16'h2222, 6'd16},
      '{2'd2, 1'b0, 5'd15, 16'h3333, 6'd47},
      '{2'd1, 1'b1, 5'd0,  16'h2222, 6'd16},
      '{2'd0, 1'b1, 5'd3,  16'h1111, 6'd3},
      '{2'd2, 1'b0, 5'd7,  16'h4444, 6'd39},
      '{2'd2, 1'b1, 5'd15, 16'h3333, 6'd47},
      '{2'd2, 1'b1, 5'd7,  16'h4444, 6'd39},
      '{2'd0, 1'b1, 5'd9,  16'h0000, 6'd9}
   };

   logic [DW-1:0] sh [NC][REG];

   task automatic client_run(input int c);
      logic [DW-1:0] got, d;
      int ra [3];
      for (int a = 0; a < REG; a++) begin
         d = DW'($urandom);
         do_write(c, a, d);
         sh[c][a] = d;
      end
      for (int j = 0; j < 12; j++) begin
         if ($urandom_range(0, 1) == 1) begin
            int la;
            la = $urandom_range(0, REG - 1);
            d  = DW'($urandom);
            do_write(c, la, d);
            sh[c][la] = d;
         end else begin
            for (int k = 0; k < 3; k++) begin
               ra[k] = $urandom_range(0, REG - 1);
               do_read(c, ra[k]);
            end
            for (int k = 0; k < 3; k++) begin
               do_pop(c, got);
               chk(got == sh[c][ra[k]], "R4 random in-order data", got, sh[c][ra[k]]);
            end
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] got, d0;
      int n0;
      bit seen;
      for (int c = 0; c < NC; c++) begin b_wa[c] = '0; b_ra[c] = '0; b_wd[c] = '0; end
      do_reset();

      // vector table walk: R1 writes, R3 read commands, R4 data
      for (int v = 0; v < 9; v++) begin
         if (VEC[v].rd) begin
            do_read(VEC[v].cli, VEC[v].la);
            chk(log_q[$].we == 0 && log_q[$].a == VEC[v].pa, "R3 read command",
                {log_q[$].we, log_q[$].a}, {1'b0, VEC[v].pa});
            do_pop(VEC[v].cli, got);
            chk(got == VEC[v].d, "R4 table read data", got, VEC[v].d);
         end else begin
            do_write(VEC[v].cli, VEC[v].la, VEC[v].d);
            chk(log_q[$].we == 1 && log_q[$].a == VEC[v].pa && log_q[$].d == VEC[v].d,
                "R1 write command", log_q[$], {1'b1, VEC[v].pa, VEC[v].d});
         end
      end

      // R2: write offered while memory refuses, then withdrawn
      n0 = log_q.size();
      dir_ready = 1'b0;
      @(negedge clk);
      b_wv[0] = 1'b1; b_wa[0] = 5'd5; b_wd[0] = 16'hAAAA;
      seen = 0;
      repeat (3) begin #2 seen |= wr_ready[0]; @(negedge clk); end
      b_wv[0] = 1'b0;
      dir_ready = 1'b1;
      chk(!seen, "R2 wr_ready low while memory busy", seen, 0);
      repeat (4) @(negedge clk);
      chk(log_q.size() == n0, "R2 dropped write not issued", log_q.size(), n0);
      do_read(0, 5);
      do_pop(0, got);
      chk(got == 16'h0000, "R2 dropped write left memory unchanged", got, 0);

      // R8: out-of-window write and read
      n0 = log_q.size();
      @(negedge clk);
      b_wv[0] = 1'b1; b_wa[0] = 5'd16; b_wd[0] = 16'hDEAD;
      #2 chk(wr_ready[0] && addr_err[0], "R8 bad write refused at once", {wr_ready[0], addr_err[0]}, 2'b11);
      @(negedge clk);
      b_wv[0] = 1'b0;
      #2 chk(addr_err[0] == 0, "R8 error is a single pulse", addr_err[0], 0);
      @(negedge clk);
      b_rv[1] = 1'b1; b_ra[1] = 5'd20;
      #2 chk(rq_ready[1] && addr_err[1], "R8 bad read refused at once", {rq_ready[1], addr_err[1]}, 2'b11);
      @(negedge clk);
      b_rv[1] = 1'b0;
      repeat (15) @(negedge clk);
      #2 chk(rt_valid[1] == 0, "R8 bad read returns nothing", rt_valid[1], 0);
      chk(log_q.size() == n0, "R8 no memory command", log_q.size(), n0);

      // R6: round-robin order from a fresh reset
      do_reset();
      fork
         do_write(0, 1, 16'hA000);
         do_write(1, 1, 16'hA001);
         do_write(2, 1, 16'hA002);
      join
      chk(log_q[0].a == 1 && log_q[1].a == 17 && log_q[2].a == 33, "R6 grant order 0,1,2",
          {log_q[0].a, log_q[1].a, log_q[2].a}, {6'd1, 6'd17, 6'd33});
      do_write(0, 2, 16'hB000);
      fork
         do_write(0, 3, 16'hC000);
         do_write(2, 3, 16'hC002);
      join
      chk(log_q[4].a == 35 && log_q[5].a == 3, "R6 pointer after client 0 favours client 2",
          {log_q[4].a, log_q[5].a}, {6'd35, 6'd3});

      // R7: write before read for the same client
      n0 = log_q.size();
      fork
         do_write(1, 4, 16'h5A5A);
         do_read(1, 4);
      join
      chk(log_q[n0].we == 1 && log_q[n0+1].we == 0, "R7 write issued before read",
          {log_q[n0].we, log_q[n0+1].we}, 2'b10);
      do_pop(1, got);
      chk(got == 16'h5A5A, "R7 read sees the earlier write", got, 16'h5A5A);

      // R9 credit limit, R5 hold
      for (int k = 0; k < 4; k++) do_read(2, 1);
      repeat (20) @(negedge clk);
      b_rv[2] = 1'b1; b_ra[2] = 5'd1;
      #2 d0 = rt_data[2*DW +: DW];
      seen = 0;
      @(negedge clk);
      repeat (20) begin #2 seen |= rq_ready[2]; @(negedge clk); end
      chk(!seen, "R9 fifth read held while four are reserved", seen, 0);
      #2 chk(rt_valid[2] && rt_data[2*DW +: DW] == d0, "R5 head held until taken",
             rt_data[2*DW +: DW], d0);
      @(negedge clk);
      b_rv[2] = 1'b0;
      do_pop(2, got);
      chk(got == 16'hA002, "R5 popped head value", got, 16'hA002);
      do_read(2, 3);
      for (int k = 0; k < 3; k++) begin
         do_pop(2, got);
         chk(got == 16'hA002, "R4 queued read data", got, 16'hA002);
      end
      do_pop(2, got);
      chk(got == 16'hC002, "R9 read admitted after pop returns its data", got, 16'hC002);

      // concurrent random phase with memory stalls
      rnd_mode = 1'b1;
      for (int c = 0; c < NC; c++) begin
         fork
            automatic int cc = c;
            client_run(cc);
         join_none
      end
      wait fork;
      rnd_mode = 1'b0;

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule